// File: doc/BRIEF.md
# Debug Register Access Port

This block is the register-file front end for a processor's eight debug register indices. It holds four breakpoint address slots, a status register and a control register. It also serves the read and write requests that arrive on a single access port. Reads are combinational from the stored registers. Writes commit on the rising clock edge. Writes to status and control always force their fixed-one bits.

Two indices are redundant names. While the debug-extensions mode input is low, index 4 is another name for status (index 6) and index 5 is another name for control (index 7). While that input is high, touching index 4 or 5 is illegal. The block raises a fault in the same cycle and leaves every register untouched.

After each committed write, the block tells the downstream breakpoint logic which slots it must re-arm. For a control write it also reports which slots changed their effective enable state. A slot's effective enable is its local enable ORed with its global enable. Matching of breakpoints and privilege checks are done elsewhere.

Top module: `dbg_access_port`

## Requirements
- R1: After reset, all four address slots read 0, status reads 0xFFFF0FF0 and control reads 0x00000400; the re-arm mask, the re-arm valid and the enable-change mask are 0.
- R2: Indices 0 to 3 read and write address slots 0 to 3 directly. The written value is stored unchanged.
- R3: While the debug-extensions input is 1, an access to index 4 or 5 asserts the fault output combinationally in the same cycle. In that case read data is 0, no register changes, and no re-arm or enable-change output is set in the following cycle. The fault output is 0 for every other access, and whenever no access is requested.
- R4: While the debug-extensions input is 0, index 4 reads and writes the status register and index 5 reads and writes the control register, exactly as indices 6 and 7 do.
- R5: A write to status stores the written value ORed with 0xFFFF0FF0.
- R6: A write to control stores the written value ORed with 0x00000400.
- R7: The control register layout is as follows. Slot i has its local enable at bit 2i and its global enable at bit 2i+1. Its 2-bit type field is at bits 16+4i and 17+4i. Type value 2 means I/O. In the cycle after a control write, the enable-change mask bit i is 1 exactly when (local OR global) of slot i differs between the old and new stored control values. After any other access the mask is 0.
- R8: In the cycle after a control write, the re-arm mask equals the enable-change mask when the old and new stored control values agree in every bit above bit 7. Otherwise the re-arm mask is 0xF.
- R9: In the cycle after a write to address slot i, the re-arm mask is the one-hot value 1<<i if slot i is enabled in the current control value and its type is not I/O. Otherwise the re-arm mask is 0.
- R10: The re-arm valid output is 1 exactly when the re-arm mask is non-zero. Re-arm outputs last one cycle. They return to 0 after a cycle that has no qualifying write, and reads never set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accIndex | input | 3 | Debug register index 0 to 7 |
| wrData | input | 32 | Write data |
| extEnable | input | 1 | Debug-extensions mode; when 1, indices 4 and 5 fault |
| rdData | output | 32 | Combinational read data for accIndex |
| illegalFault | output | 1 | Illegal-opcode fault for the current access |
| rearmValid | output | 1 | Re-arm mask is non-zero |
| rearmMask | output | 4 | Slots to re-arm, one cycle after the write |
| enChanged | output | 4 | Slots whose effective enable changed on the last control write |

## Verification
A stored register that was corrupted, or a fixed-one mask that was lost, shows on rdData at the next read of that index, because read data has no pipeline. The bench therefore reads registers back frequently in its random mix, and a wrong value is caught within a few accesses. Errors in the old-versus-new control comparison, or in the fold of the enable pair, show one cycle after the control write on enChanged and rearmMask. That is one half cycle after the commit edge, where the bench samples them. A decoder that mishandles the alias shows up as a missing or spurious fault pulse in the same cycle as the access, or as a later read of status or control that does not match.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;

  localparam int NUM_SLOTS = 4;
  localparam int IDX_W     = 3;
  localparam int SLOT_W    = 2;

  typedef enum logic [1:0] {
    SRC_SLOT = 2'd0,
    SRC_STAT = 2'd1,
    SRC_CTRL = 2'd2,
    SRC_NONE = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic                wrSlot;
    logic                wrStat;
    logic                wrCtrl;
    logic                fault;
    logic [SLOT_W-1:0]   slotSel;
    rdSrc_e              rdSrc;
  } strobe_t;

endpackage

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
  import dbg_access_pkg::*;
(
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [IDX_W-1:0] accIndex,
  input  logic             extEnable,
  output strobe_t          stb
);

  logic isAliasIdx;
  logic blocked;
  logic doWrite;

  assign isAliasIdx = (accIndex == 3'd4) || (accIndex == 3'd5);
  assign blocked    = extEnable && isAliasIdx;
  assign doWrite    = accValid && accWrite && !blocked;

  always_comb begin
    stb         = '0;
    stb.rdSrc   = SRC_NONE;
    stb.slotSel = accIndex[SLOT_W-1:0];
    stb.fault   = accValid && blocked;
    if (!blocked) begin
      unique case (accIndex)
        3'd0, 3'd1, 3'd2, 3'd3: begin
          stb.rdSrc  = SRC_SLOT;
          stb.wrSlot = doWrite;
        end
        3'd4, 3'd6: begin
          stb.rdSrc  = SRC_STAT;
          stb.wrStat = doWrite;
        end
        default: begin
          stb.rdSrc  = SRC_CTRL;
          stb.wrCtrl = doWrite;
        end
      endcase
    end
  end

endmodule

// File: rtl/dbg_access_datapath.sv
module dbg_access_datapath
  import dbg_access_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] STAT_ONES = 32'hFFFF0FF0,
  parameter logic [DATA_W-1:0] CTRL_ONES = 32'h00000400,
  parameter int              TYPE_LSB  = 16,
  parameter int              ENA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_SLOTS-1:0] rearmMask,
  output logic [NUM_SLOTS-1:0] enChanged
);

  localparam logic [1:0]        IO_TYPE = 2'd2;
  localparam logic [DATA_W-1:0] HI_MASK = ~((DATA_W'(1) << ENA_BITS) - DATA_W'(1));

  logic [DATA_W-1:0]    slotQ [NUM_SLOTS];
  logic [DATA_W-1:0]    statQ;
  logic [DATA_W-1:0]    ctrlQ;
  logic [DATA_W-1:0]    newCtrl;
  logic [NUM_SLOTS-1:0] oldEn;
  logic [NUM_SLOTS-1:0] newEn;
  logic [NUM_SLOTS-1:0] slotArm;
  logic [NUM_SLOTS-1:0] nextChg;
  logic [NUM_SLOTS-1:0] nextMask;
  logic                 onlyEnables;

  assign newCtrl = wrData | CTRL_ONES;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign oldEn[i]   = |ctrlQ[2*i +: 2];
    assign newEn[i]   = |newCtrl[2*i +: 2];
    assign slotArm[i] = stb.wrSlot && (stb.slotSel == SLOT_W'(i)) && oldEn[i]
                        && (ctrlQ[TYPE_LSB + 4*i +: 2] != IO_TYPE);
  end

  assign onlyEnables = ((ctrlQ ^ newCtrl) & HI_MASK) == '0;

  always_comb begin
    nextChg  = '0;
    nextMask = '0;
    if (stb.wrCtrl) begin
      nextChg  = oldEn ^ newEn;
      nextMask = onlyEnables ? (oldEn ^ newEn) : '1;
    end else if (stb.wrSlot) begin
      nextMask = slotArm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotQ[i] <= '0;
      statQ     <= STAT_ONES;
      ctrlQ     <= CTRL_ONES;
      rearmMask <= '0;
      enChanged <= '0;
    end else begin
      if (stb.wrSlot) slotQ[stb.slotSel] <= wrData;
      if (stb.wrStat) statQ <= wrData | STAT_ONES;
      if (stb.wrCtrl) ctrlQ <= newCtrl;
      rearmMask <= nextMask;
      enChanged <= nextChg;
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_SLOT: rdData = slotQ[stb.slotSel];
      SRC_STAT: rdData = statQ;
      SRC_CTRL: rdData = ctrlQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dbg_access_port.sv
module dbg_access_port
  import dbg_access_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        accIndex,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              illegalFault,
  output logic              rearmValid,
  output logic [3:0]        rearmMask,
  output logic [3:0]        enChanged
);

  strobe_t stb;

  dbg_access_ctrl u_ctrl (
    .accValid  (accValid),
    .accWrite  (accWrite),
    .accIndex  (accIndex),
    .extEnable (extEnable),
    .stb       (stb)
  );

  dbg_access_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .rdData    (rdData),
    .rearmMask (rearmMask),
    .enChanged (enChanged)
  );

  assign illegalFault = stb.fault;
  assign rearmValid   = |rearmMask;

endmodule

// File: rtl/dbg_access_checker.sv
module dbg_access_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [2:0]        accIndex,
  input logic              extEnable,
  input logic [DATA_W-1:0] rdData,
  input logic              illegalFault,
  input logic              rearmValid,
  input logic [3:0]        rearmMask,
  input logic [3:0]        enChanged
);

  logic commitWr;
  logic ctrlWr;
  logic slotWr;
  assign commitWr = accValid && accWrite && !illegalFault;
  assign ctrlWr   = commitWr && ((accIndex == 3'd7) || (accIndex == 3'd5 && !extEnable));
  assign slotWr   = commitWr && (accIndex < 3'd4);

  AST_FAULT_ONLY_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    illegalFault |-> (accValid && extEnable && (accIndex == 3'd4 || accIndex == 3'd5))); // R3
  AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalFault |-> (rdData == '0)); // R3
  AST_FAULT_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    illegalFault |=> !rearmValid); // R3
  AST_STAT_FIXED_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accIndex == 3'd6) |-> ((rdData & 32'hFFFF0FF0) == 32'hFFFF0FF0)); // R5
  AST_CTRL_FIXED_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accIndex == 3'd7) |-> rdData[10]); // R6
  AST_CHG_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> ((enChanged & ~rearmMask) == 4'h0)); // R8
  AST_CHG_ONLY_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> (enChanged == 4'h0)); // R7
  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    slotWr |=> ($countones(rearmMask) <= 1)); // R9
  AST_REARM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !commitWr |=> !rearmValid); // R10
  AST_VALID_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rearmValid == (rearmMask != 4'h0)); // R10

endmodule

bind dbg_access_port dbg_access_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accIndex     (accIndex),
  .extEnable    (extEnable),
  .rdData       (rdData),
  .illegalFault (illegalFault),
  .rearmValid   (rearmValid),
  .rearmMask    (rearmMask),
  .enChanged    (enChanged)
);

// File: tb/dbg_access_port_test.sv
module dbg_access_port_test;

  localparam logic [31:0] ST1 = 32'hFFFF0FF0;
  localparam logic [31:0] CT1 = 32'h00000400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [2:0]  accIndex = '0;
  logic [31:0] wrData = '0;
  logic        extEnable = 1'b0;
  logic [31:0] rdData;
  logic        illegalFault;
  logic        rearmValid;
  logic [3:0]  rearmMask;
  logic [3:0]  enChanged;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic [31:0] mSlot [4];
  logic [31:0] mStat;
  logic [31:0] mCtrl;

  always #5 clk = ~clk;

  dbg_access_port uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accIndex(accIndex), .wrData(wrData), .extEnable(extEnable),
    .rdData(rdData), .illegalFault(illegalFault), .rearmValid(rearmValid),
    .rearmMask(rearmMask), .enChanged(enChanged)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  function automatic logic [3:0] enOf(logic [31:0] c);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = c[2*i] | c[2*i+1];
    return e;
  endfunction

  function automatic logic [31:0] modelRead(int idx);
    if (idx < 4) return mSlot[idx];
    if (idx == 6) return mStat;
    return mCtrl;
  endfunction

  // Drives one access at a negedge; leaves the bench at the following negedge.
  task automatic doAccess(bit wr, int idx, logic [31:0] d, bit ext);
    bit         expFault;
    int         eff;
    logic [31:0] nc;
    logic [3:0] expMask;
    logic [3:0] expChg;
    expFault = ext && (idx == 4 || idx == 5);
    eff = (idx == 4) ? 6 : (idx == 5) ? 7 : idx;
    accValid = 1'b1; accWrite = wr; accIndex = 3'(idx); wrData = d; extEnable = ext;
    #1;
    chk("R3 fault", 32'(illegalFault), 32'(expFault));
    if (expFault) chk("R3 fault read zero", rdData, 32'h0);
    else if (!wr) chk((idx == 4 || idx == 5) ? "R4 alias read" : (idx < 4) ? "R2 slot read" : "R1/R5/R6 read",
                      rdData, modelRead(eff));
    expMask = 4'h0;
    expChg  = 4'h0;
    if (wr && !expFault) begin
      if (eff < 4) begin
        if (enOf(mCtrl)[eff] && (mCtrl[16+4*eff +: 2] != 2'd2)) expMask = 4'(1 << eff);
        mSlot[eff] = d;
      end else if (eff == 6) begin
        mStat = d | ST1;
      end else begin
        nc = d | CT1;
        expChg  = enOf(mCtrl) ^ enOf(nc);
        expMask = (((mCtrl ^ nc) & 32'hFFFFFF00) == 0) ? expChg : 4'hF;
        mCtrl = nc;
      end
    end
    @(negedge clk);
    chk("R7 enChanged", 32'(enChanged), 32'(expChg));
    chk(eff < 4 ? "R9 slot rearm" : "R8 rearm mask", 32'(rearmMask), 32'(expMask));
    chk("R10 rearm valid", 32'(rearmValid), 32'(expMask != 0));
  endtask

  task automatic idleCheck();
    accValid = 1'b0;
    @(negedge clk);
    chk("R10 pulse ends", {27'h0, rearmValid, rearmMask}, 32'h0);
    chk("R3 no fault idle", 32'(illegalFault), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) mSlot[i] = '0;
    mStat = ST1;
    mCtrl = CT1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset rearm", {23'h0, rearmValid, rearmMask, enChanged}, 32'h0);
    for (int i = 0; i < 8; i++) doAccess(1'b0, i, 32'h0, 1'b0);

    // R2 slot writes, R5/R6 fixed ones
    doAccess(1'b1, 0, 32'hDEADBEEF, 1'b0);
    doAccess(1'b0, 0, 32'h0, 1'b0);
    doAccess(1'b1, 6, 32'h00000000, 1'b0);
    doAccess(1'b0, 6, 32'h0, 1'b0);
    doAccess(1'b1, 7, 32'h00000000, 1'b0);
    doAccess(1'b0, 7, 32'h0, 1'b0);
    // R7/R8: enable-only change on slot 1
    doAccess(1'b1, 7, 32'h00000004, 1'b0);
    idleCheck();
    // R8: type change forces all slots; slot 2 enabled as I/O
    doAccess(1'b1, 7, 32'h02000424, 1'b0);
    // R9: slot 1 enabled, non-I/O; slot 2 I/O; slot 3 disabled
    doAccess(1'b1, 1, 32'h00001000, 1'b0);
    doAccess(1'b1, 2, 32'h00002000, 1'b0);
    doAccess(1'b1, 3, 32'h00003000, 1'b0);
    // R3: faults leave status/control unchanged
    doAccess(1'b1, 4, 32'h12345678, 1'b1);
    doAccess(1'b1, 5, 32'h00000000, 1'b1);
    doAccess(1'b0, 4, 32'h0, 1'b1);
    doAccess(1'b0, 6, 32'h0, 1'b1);
    doAccess(1'b0, 7, 32'h0, 1'b1);
    // R4: aliases with extensions off
    doAccess(1'b1, 4, 32'h0000F00F, 1'b0);
    doAccess(1'b0, 6, 32'h0, 1'b0);
    doAccess(1'b1, 5, 32'h00000081, 1'b0);
    doAccess(1'b0, 5, 32'h0, 1'b0);
    doAccess(1'b0, 7, 32'h0, 1'b0);
    idleCheck();

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int  idx;
      bit  wr;
      bit  ext;
      logic [31:0] d;
      idx = int'($urandom_range(0, 7));
      wr  = $urandom_range(0, 1) == 1;
      ext = $urandom_range(0, 3) == 0;
      d   = $urandom();
      if ($urandom_range(0, 2) == 0) d = (mCtrl & 32'hFFFFFF00) | (d & 32'hFF);
      doAccess(wr, idx, d, ext);
      if ($urandom_range(0, 7) == 0) idleCheck();
    end
    idleCheck();
    finishRun();
  end

endmodule